// File: doc/BRIEF.md
# Time-of-Day Counter with Hourly Chime

This block keeps the time of day as hours, minutes and seconds in 24-hour form. Every field is held as two BCD digits, so a display stage can use them with no conversion. The count moves forward by one second on each cycle in which a one-pulse-per-second enable is high. When the count wraps from 23:59:59 back to midnight, the block raises a one-cycle pulse that a calendar stage can use to step the date.

A hold input puts the counter into setting mode. While it is high, the seconds enable has no effect. Strobes from a setting controller then step the minutes field or the hours field by one, and each field wraps at its own maximum without carrying into the next field.

An LED output stands in for a buzzer and marks the end of every hour. When the count reaches minute 59, second 50, the LED turns on. It then changes state on every following second until the hour rolls over, and it stays dark at all other times. Clock division, key debouncing and display decoding belong to other blocks.

Top module: `tod_chime_counter`

## Requirements
- R1: After reset all six digits read 0 (time 00:00:00), the chime LED is off and the day pulse is low.
- R2: With hold low, each cycle where the tick enable is high advances seconds by exactly one. Cycles without a tick leave the time unchanged.
- R3: Seconds wrap 59 to 00 and step minutes on that same tick. Minutes wrap 59 to 00 and step hours on that same tick.
- R4: On the tick that leaves 23:59:59, every field becomes 00 on the same edge. The day pulse is high for exactly the one cycle that follows, and it is never high at any other time.
- R5: Each field is output as a tens digit and a ones digit, each a 4-bit BCD value 0 to 9. Seconds and minutes never exceed 59, and hours never exceed 23.
- R6: While hold is high, ticks have no effect on the time.
- R7: While hold is high, a minute strobe adds one to minutes with a wrap from 59 to 00, and it leaves hours unchanged. An hour strobe adds one to hours with a wrap from 23 to 00, and it raises no day pulse.
- R8: While hold is low, the minute and hour strobes have no effect.
- R9: The chime LED turns on on the tick that reaches minute 59, second 50. It then inverts on every tick: it is on at even seconds 50 to 58 and off at second 59 and at 00:00. Outside minute 59, seconds 50 to 59, it is off.
- R10: Reset overrides every other input, including a tick or a strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse once per second |
| hold | input | 1 | High selects setting mode and freezes the count |
| inc_min | input | 1 | Minute increment strobe, used in setting mode |
| inc_hour | input | 1 | Hour increment strobe, used in setting mode |
| hr_hi | output | 4 | Hours tens digit |
| hr_lo | output | 4 | Hours ones digit |
| min_hi | output | 4 | Minutes tens digit |
| min_lo | output | 4 | Minutes ones digit |
| sec_hi | output | 4 | Seconds tens digit |
| sec_lo | output | 4 | Seconds ones digit |
| day_carry | output | 1 | One-cycle pulse after the midnight rollover |
| chime_led | output | 1 | Blinking end-of-hour indicator |

## Verification
The properties assume that reset is held high from time zero until the first edges have passed. They also assume that the tick and the strobes are single-cycle pulses, driven only from the system clock domain.

The freeze and ignore properties further assume that a strobe arrives only in the mode that accepts it, or is harmless otherwise. The bench therefore raises strobes while hold is low only in order to confirm that nothing moves.

All stimulus changes on the falling clock edge, and every strobe or tick lasts exactly one cycle. Hold is switched only between pulses, so no edge sees a mode change and a pulse together.

// File: rtl/tod_pkg.sv
package tod_pkg;
   typedef logic [3:0] bcd_t;
   localparam bcd_t BCD_NINE = 4'd9;
endpackage

// File: rtl/tod_bcd_field.sv
module tod_bcd_field
   import tod_pkg::*;
#(
   parameter int LIMIT = 59
) (
   input  logic clk,
   input  logic rst,
   input  logic step,
   output bcd_t hi,
   output bcd_t lo,
   output logic at_max
);
   localparam bcd_t LIM_HI = bcd_t'(LIMIT / 10);
   localparam bcd_t LIM_LO = bcd_t'(LIMIT % 10);

   generate
      if (LIMIT < 1 || LIMIT > 99) begin : g_bad_limit
         $error("tod_bcd_field: LIMIT must lie in 1..99");
      end
   endgenerate

   assign at_max = (hi == LIM_HI) && (lo == LIM_LO);

   always_ff @(posedge clk) begin
      if (rst) begin
         hi <= '0;
         lo <= '0;
      end else if (step) begin
         if (at_max) begin
            hi <= '0;
            lo <= '0;
         end else if (lo == BCD_NINE) begin
            hi <= hi + 4'd1;
            lo <= '0;
         end else begin
            lo <= lo + 4'd1;
         end
      end
   end
endmodule

// File: rtl/tod_chime.sv
module tod_chime
   import tod_pkg::*;
#(
   parameter int SEC_LIMIT = 59,
   parameter int CHIME_SEC = 50
) (
   input  logic clk,
   input  logic rst,
   input  logic run_tick,
   input  logic min_at_max,
   input  bcd_t sec_hi,
   input  bcd_t sec_lo,
   output logic led
);
   localparam int SW = $clog2(SEC_LIMIT + 1) + 1;

   generate
      if (CHIME_SEC < 1 || CHIME_SEC > SEC_LIMIT) begin : g_bad_chime
         $error("tod_chime: CHIME_SEC must lie in 1..SEC_LIMIT");
      end
   endgenerate

   logic [SW-1:0] sec_val;
   logic          in_win;
   logic          pre_win;

   assign sec_val = SW'(sec_hi) * SW'(10) + SW'(sec_lo);
   assign in_win  = min_at_max && (sec_val >= SW'(CHIME_SEC));
   assign pre_win = min_at_max && (sec_val >= SW'(CHIME_SEC - 1))
                    && (sec_val < SW'(SEC_LIMIT));

   always_ff @(posedge clk) begin
      if (rst)                     led <= 1'b0;
      else if (run_tick && pre_win) led <= ~led;
      else if (run_tick || !in_win) led <= 1'b0;
   end
endmodule

// File: rtl/tod_chime_counter.sv
module tod_chime_counter
   import tod_pkg::*;
#(
   parameter int SEC_LIMIT  = 59,
   parameter int MIN_LIMIT  = 59,
   parameter int HOUR_LIMIT = 23,
   parameter int CHIME_SEC  = 50
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       tick,
   input  logic       hold,
   input  logic       inc_min,
   input  logic       inc_hour,
   output logic [3:0] hr_hi,
   output logic [3:0] hr_lo,
   output logic [3:0] min_hi,
   output logic [3:0] min_lo,
   output logic [3:0] sec_hi,
   output logic [3:0] sec_lo,
   output logic       day_carry,
   output logic       chime_led
);
   logic run_tick;
   logic sec_max, min_max, hr_max;
   logic sec_step, min_step, hr_step;

   assign run_tick = tick && !hold;
   assign sec_step = run_tick;
   assign min_step = hold ? inc_min  : (run_tick && sec_max);
   assign hr_step  = hold ? inc_hour : (run_tick && sec_max && min_max);

   tod_bcd_field #(.LIMIT(SEC_LIMIT)) i_sec (
      .clk(clk), .rst(rst), .step(sec_step),
      .hi(sec_hi), .lo(sec_lo), .at_max(sec_max));

   tod_bcd_field #(.LIMIT(MIN_LIMIT)) i_min (
      .clk(clk), .rst(rst), .step(min_step),
      .hi(min_hi), .lo(min_lo), .at_max(min_max));

   tod_bcd_field #(.LIMIT(HOUR_LIMIT)) i_hour (
      .clk(clk), .rst(rst), .step(hr_step),
      .hi(hr_hi), .lo(hr_lo), .at_max(hr_max));

   tod_chime #(.SEC_LIMIT(SEC_LIMIT), .CHIME_SEC(CHIME_SEC)) i_chime (
      .clk(clk), .rst(rst), .run_tick(run_tick), .min_at_max(min_max),
      .sec_hi(sec_hi), .sec_lo(sec_lo), .led(chime_led));

   always_ff @(posedge clk) begin
      if (rst) day_carry <= 1'b0;
      else     day_carry <= run_tick && sec_max && min_max && hr_max;
   end
endmodule

// File: rtl/tod_chime_counter_chk.sv
module tod_chime_counter_chk (
   input logic       clk,
   input logic       rst,
   input logic       tick,
   input logic       hold,
   input logic       inc_min,
   input logic       inc_hour,
   input logic [3:0] hr_hi,
   input logic [3:0] hr_lo,
   input logic [3:0] min_hi,
   input logic [3:0] min_lo,
   input logic [3:0] sec_hi,
   input logic [3:0] sec_lo,
   input logic       day_carry,
   input logic       chime_led
);
   logic [23:0] now_t;
   logic        win;
   assign now_t = {hr_hi, hr_lo, min_hi, min_lo, sec_hi, sec_lo};
   assign win   = ({min_hi, min_lo} == 8'h59) && ({sec_hi, sec_lo} >= 8'h50);

   p_digits_r5: assert property (@(posedge clk) disable iff (rst)
      (hr_lo <= 4'd9) && (min_lo <= 4'd9) && (sec_lo <= 4'd9) &&
      ({hr_hi, hr_lo} <= 8'h23) && ({min_hi, min_lo} <= 8'h59) &&
      ({sec_hi, sec_lo} <= 8'h59));

   p_carry_midnight_r4: assert property (@(posedge clk) disable iff (rst)
      day_carry |-> (now_t == 24'h0));

   p_carry_single_r4: assert property (@(posedge clk) disable iff (rst)
      day_carry |=> !day_carry);

   p_hold_frozen_r6: assert property (@(posedge clk) disable iff (rst)
      (hold && !inc_min && !inc_hour) |=> $stable(now_t));

   p_strobe_ignored_r8: assert property (@(posedge clk) disable iff (rst)
      (!hold && !tick) |=> $stable(now_t));

   p_led_outside_r9: assert property (@(posedge clk) disable iff (rst)
      (!win && !$past(win)) |-> !chime_led);

   p_reset_r10: assert property (@(posedge clk)
      rst |=> (now_t == 24'h0) && !chime_led && !day_carry);
endmodule

bind tod_chime_counter tod_chime_counter_chk i_chk (
   .clk(clk), .rst(rst), .tick(tick), .hold(hold),
   .inc_min(inc_min), .inc_hour(inc_hour),
   .hr_hi(hr_hi), .hr_lo(hr_lo), .min_hi(min_hi), .min_lo(min_lo),
   .sec_hi(sec_hi), .sec_lo(sec_lo),
   .day_carry(day_carry), .chime_led(chime_led));

// File: tb/test_tod_chime_counter.sv
module test_tod_chime_counter;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic tick = 1'b0, hold = 1'b0, inc_min = 1'b0, inc_hour = 1'b0;
   logic [3:0] hr_hi, hr_lo, min_hi, min_lo, sec_hi, sec_lo;
   logic day_carry, chime_led;
   int checks = 0, errors = 0, carry_seen = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   tod_chime_counter i_tod_chime_counter (
      .clk(clk), .rst(rst), .tick(tick), .hold(hold),
      .inc_min(inc_min), .inc_hour(inc_hour),
      .hr_hi(hr_hi), .hr_lo(hr_lo), .min_hi(min_hi), .min_lo(min_lo),
      .sec_hi(sec_hi), .sec_lo(sec_lo),
      .day_carry(day_carry), .chime_led(chime_led));

   always @(posedge clk) if (!rst && day_carry) carry_seen++;

   function automatic logic [23:0] now_t();
      return {hr_hi, hr_lo, min_hi, min_lo, sec_hi, sec_lo};
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic pulse_tick(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick = 1'b1;
         @(negedge clk) tick = 1'b0;
      end
   endtask

   task automatic pulse_min(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) inc_min = 1'b1;
         @(negedge clk) inc_min = 1'b0;
      end
   endtask

   task automatic pulse_hour(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) inc_hour = 1'b1;
         @(negedge clk) inc_hour = 1'b0;
      end
   endtask

   task automatic t_reset();
      chk("R1 time", now_t(), 24'h000000);
      chk("R1 led", chime_led, 0);
      chk("R1 carry", day_carry, 0);
   endtask

   task automatic t_count();
      pulse_tick(5);
      chk("R2 five ticks", now_t(), 24'h000005);
      repeat (10) @(negedge clk);
      chk("R2 no tick idle", now_t(), 24'h000005);
      pulse_tick(55);
      chk("R3 sec carry", now_t(), 24'h000100);
   endtask

   task automatic t_hold();
      @(negedge clk) hold = 1'b1;
      pulse_tick(3);
      chk("R6 ticks frozen", now_t(), 24'h000100);
   endtask

   task automatic t_set();
      pulse_min(58);
      chk("R5 min digits 5,9", {min_hi, min_lo}, 8'h59);
      pulse_min(1);
      chk("R7 min wrap no hour", now_t(), 24'h000000);
      pulse_hour(23);
      chk("R7 hour 23", now_t(), 24'h230000);
      pulse_hour(1);
      chk("R7 hour wrap", now_t(), 24'h000000);
      chk("R7 no day pulse", carry_seen, 0);
      pulse_hour(23);
      pulse_min(59);
      chk("R7 set 23:59", now_t(), 24'h235900);
   endtask

   task automatic t_ignored();
      @(negedge clk) hold = 1'b0;
      pulse_min(1);
      pulse_hour(1);
      chk("R8 strobes ignored", now_t(), 24'h235900);
   endtask

   task automatic t_chime();
      pulse_tick(49);
      chk("R9 time 59:49", now_t(), 24'h235949);
      chk("R9 led off before", chime_led, 0);
      pulse_tick(1);
      chk("R9 led on at 50", chime_led, 1);
      pulse_tick(1);
      chk("R9 led off at 51", chime_led, 0);
      pulse_tick(7);
      chk("R9 led on at 58", chime_led, 1);
      pulse_tick(1);
      chk("R9 led off at 59", chime_led, 0);
      chk("R3 time 23:59:59", now_t(), 24'h235959);
   endtask

   task automatic t_midnight();
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      chk("R4 rollover time", now_t(), 24'h000000);
      chk("R4 carry high", day_carry, 1);
      chk("R9 led off at 00", chime_led, 0);
      @(negedge clk);
      chk("R4 carry one cycle", day_carry, 0);
      chk("R4 single pulse total", carry_seen, 1);
   endtask

   task automatic t_reset_override();
      pulse_tick(3);
      @(negedge clk) begin rst = 1'b1; tick = 1'b1; inc_min = 1'b1; end
      @(negedge clk) begin rst = 1'b0; tick = 1'b0; inc_min = 1'b0; end
      chk("R10 reset wins", now_t(), 24'h000000);
      chk("R10 carry low", day_carry, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_count();
      t_hold();
      t_set();
      t_ignored();
      t_chime();
      t_midnight();
      t_reset_override();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #1500000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule